// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two digitised supervisory inputs into a processor reset. One input is a "supply under threshold" flag from an external comparator. The other is an active-low push-button or logic reset. The block produces an active-low reset and an active-high copy of the same reset. Each copy comes from its own output register, and the two are always exact complements.

Either input, while active, holds reset asserted with no timeout. When both inputs are clear, a down-counter measures a release interval, and reset lets go only when that interval has run out. Any new hold condition during a pulse reloads the counter to its full value. A brownout mid-pulse therefore stretches the pulse, and a bouncing button is absorbed without any further transitions. The count is the larger of the nominal release delay and the minimum pulse width, both given in clock cycles.

Both inputs pass through a synchroniser of `SYNC_STAGES` flops. While the synchronous reset `rst_i` is high, the synchroniser reads as "hold", the counter is loaded, and the reset outputs are asserted.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_low_i` is 1, `rst_n_o` is 0 with no timeout. A rise of `supply_low_i` driven between edges makes `rst_n_o` fall at the 3rd rising clock edge after the change (defaults: 2 synchroniser stages plus 1 output register).
- R2: Let LOAD = max(`RELEASE_CYCLES`, `MIN_PULSE_CYCLES`). Once the last hold condition clears, `rst_n_o` rises at the (LOAD+3)th rising edge after that input change.
- R3: A return of `supply_low_i` to 1 while a pulse is still running restarts the release interval. The rise then comes LOAD+3 edges after the final recovery, and there is no extra edge on `rst_n_o`.
- R4: Driving `mr_n_i` to 0 asserts reset with the same 3-edge latency. Reset is released LOAD+3 edges after `mr_n_i` returns to 1, and the low pulse lasts at least `MIN_PULSE_CYCLES` cycles.
- R5: Toggling `mr_n_i` repeatedly inside a pulse yields exactly one fall and one rise of `rst_n_o`. The rise is timed from the last 0-to-1 change.
- R6: On every cycle, `rst_o` equals the inverse of `rst_n_o`.
- R7: While `rst_i` is 1, `rst_n_o` is 0 and `rst_o` is 1. If the inputs are inactive when `rst_i` drops between edges, `rst_n_o` rises at the (LOAD+3)th edge after the drop.
- R8: When both inputs overlap, reset holds until both are clear. The release is timed from whichever input cleared last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high initialisation |
| supply_low_i | input | 1 | 1 = supply below threshold (from comparator) |
| mr_n_i | input | 1 | Manual reset request, active low |
| rst_n_o | output | 1 | Processor reset, active low (registered) |
| rst_o | output | 1 | Processor reset, active high (registered) |

## Verification
On every cycle the assertions check several internal relations. A synchronised hold request always forces the reset low on the next cycle and reloads the counter. With no hold, the counter steps down by exactly one. A rising reset is only seen after a zero count with no hold, every low pulse lasts at least the minimum width, and the two outputs stay complementary. Only the bench scenarios can show the end-to-end latencies from the pins: the absence of spurious edges while a button bounces or a brownout interrupts a pulse, the indefinite hold during a long supply fault, and the ordering of overlapping supply and button causes.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Bit positions of the hold causes inside the synchronised vector
  localparam int CAUSE_SUPPLY = 0;
  localparam int CAUSE_MANUAL = 1;
  localparam int CAUSE_N      = 2;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/supv_cause_merge.sv
module supv_cause_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] cause_i,
  output logic         hold_o
);

  logic [N:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign chain[i+1] = chain[i] | cause_i[i];
  end
  assign hold_o = chain[N];

endmodule

// File: rtl/supv_delay_ctr.sv
module supv_delay_ctr #(
  parameter int LOAD  = 400,
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || reload_i) begin
      cnt_q <= LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int SYNC_STAGES      = 2,
  parameter int RELEASE_CYCLES   = 400,
  parameter int MIN_PULSE_CYCLES = 280
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic supply_low_i,
  input  logic mr_n_i,
  output logic rst_n_o,
  output logic rst_o
);

  localparam int LOAD  = max_i(RELEASE_CYCLES, MIN_PULSE_CYCLES);
  localparam int CNT_W = $clog2(LOAD + 1);

  logic [CAUSE_N-1:0] cause_raw;
  logic [CAUSE_N-1:0] cause_sync;
  logic               hold_req;
  logic [CNT_W-1:0]   cnt_q;
  logic               cnt_zero;
  logic               active;
  logic               rst_n_q;
  logic               rst_q;

  // Normalise both causes to active-high before synchronising
  assign cause_raw[CAUSE_SUPPLY] = supply_low_i;
  assign cause_raw[CAUSE_MANUAL] = ~mr_n_i;

  supv_sync #(
    .W       (CAUSE_N),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({CAUSE_N{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (cause_raw),
    .q_o   (cause_sync)
  );

  supv_cause_merge #(
    .N (CAUSE_N)
  ) u_merge (
    .cause_i (cause_sync),
    .hold_o  (hold_req)
  );

  supv_delay_ctr #(
    .LOAD  (LOAD),
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .reload_i (hold_req),
    .cnt_o    (cnt_q),
    .zero_o   (cnt_zero)
  );

  assign active = hold_req | ~cnt_zero;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      rst_n_q <= ~active;
      rst_q   <= active;
    end
  end

  assign rst_n_o = rst_n_q;
  assign rst_o   = rst_q;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int LOAD      = 400,
  parameter int MIN_PULSE = 280,
  parameter int CNT_W     = 9
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             rst_n_o,
  input logic             rst_o,
  input logic             hold_req,
  input logic [CNT_W-1:0] cnt_q
);

  logic [31:0] low_run;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      low_run <= '0;
    end else if (!rst_n_o) begin
      if (low_run != 32'hFFFF_FFFF) low_run <= low_run + 1;
    end else begin
      low_run <= '0;
    end
  end

  assert_hold_low_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_req |=> !rst_n_o);

  assert_reload_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_req |=> (cnt_q == CNT_W'(LOAD)));

  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!hold_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_release_gate_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rst_n_o) |-> ($past(cnt_q) == '0 && !$past(hold_req)));

  assert_min_width_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rst_n_o) |-> (low_run >= 32'(MIN_PULSE)));

  assert_complement_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    rst_o == !rst_n_o);

endmodule

bind supv_reset_gen supv_reset_gen_chk #(
  .LOAD      (LOAD),
  .MIN_PULSE (MIN_PULSE_CYCLES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .rst_n_o  (rst_n_o),
  .rst_o    (rst_o),
  .hold_req (hold_req),
  .cnt_q    (cnt_q)
);

// File: tb/supv_reset_gen_tb.sv
`timescale 1ns/1ps
module supv_reset_gen_tb;

  localparam int SYNC = 2;
  localparam int REL  = 40;
  localparam int MINP = 28;
  localparam int LOAD = (REL > MINP) ? REL : MINP;
  localparam int FALL_LAT = SYNC + 1;
  localparam int RISE_LAT = LOAD + SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic rst_n;
  logic rst_h;

  supv_reset_gen #(
    .SYNC_STAGES      (SYNC),
    .RELEASE_CYCLES   (REL),
    .MIN_PULSE_CYCLES (MINP)
  ) u_dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .supply_low_i (supply_low),
    .mr_n_i       (mr_n),
    .rst_n_o      (rst_n),
    .rst_o        (rst_h)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit    rise;
    int    at;
    bit    min_chk;
    string req;
  } ev_t;

  ev_t expq[$];
  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_fall(input string req);
    ev_t e;
    e.rise = 0; e.at = cyc + FALL_LAT; e.min_chk = 0; e.req = req;
    expq.push_back(e);
  endtask

  task automatic expect_rise(input string req, input bit mchk);
    ev_t e;
    e.rise = 1; e.at = cyc + RISE_LAT; e.min_chk = mchk; e.req = req;
    expq.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected edges as the design produces them
  logic prev_n = 1'b0;
  int   last_fall = 0;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(rst_h === ~rst_n, "R6", "rst_o vs ~rst_n_o", int'(rst_h), int'(~rst_n));
      if (rst_n !== prev_n) begin
        if (expq.size() == 0) begin
          chk(0, "R5", "unexpected edge on rst_n_o, new level", int'(rst_n), int'(prev_n));
        end else begin
          ev_t e;
          e = expq.pop_front();
          chk(int'(rst_n) == int'(e.rise), e.req, "edge direction", int'(rst_n), int'(e.rise));
          chk(cyc == e.at, e.req, "edge cycle", cyc, e.at);
          if (e.rise && e.min_chk)
            chk((cyc - last_fall) >= MINP, e.req, "pulse width >= minimum",
                cyc - last_fall, MINP);
        end
        if (!rst_n) last_fall = cyc;
      end
    end
    prev_n = rst_n;
  end

  initial begin
    // R7: reset state
    step(5);
    chk(rst_n === 1'b0, "R7", "rst_n_o during rst_i", int'(rst_n), 0);
    chk(rst_h === 1'b1, "R7", "rst_o during rst_i", int'(rst_h), 1);
    rst = 1'b0;
    expect_rise("R7", 0);
    step(RISE_LAT + 5);

    // R1 + R2: long supply fault, no timeout, then timed release
    supply_low = 1'b1; expect_fall("R1");
    step(100);
    chk(rst_n === 1'b0, "R1", "rst_n_o after long fault", int'(rst_n), 0);
    supply_low = 1'b0; expect_rise("R2", 0);
    step(RISE_LAT + 5);

    // R3: brownout during a running pulse
    supply_low = 1'b1; expect_fall("R3");
    step(10);
    supply_low = 1'b0;
    step(20);
    chk(rst_n === 1'b0, "R3", "rst_n_o mid-pulse", int'(rst_n), 0);
    supply_low = 1'b1;
    step(5);
    supply_low = 1'b0; expect_rise("R3", 1);
    step(RISE_LAT + 5);

    // R4: short manual press
    mr_n = 1'b0; expect_fall("R4");
    step(3);
    mr_n = 1'b1; expect_rise("R4", 1);
    step(RISE_LAT + 5);

    // R5: bouncing manual input
    mr_n = 1'b0; expect_fall("R5");
    for (int i = 0; i < 7; i++) begin
      step(2);
      mr_n = ~mr_n;
    end
    expect_rise("R5", 1);
    step(RISE_LAT + 5);
    chk(rst_n === 1'b1, "R5", "rst_n_o after bounce settles", int'(rst_n), 1);

    // R8: overlapping supply fault and manual press
    supply_low = 1'b1; expect_fall("R8");
    step(4);
    mr_n = 1'b0;
    step(10);
    supply_low = 1'b0;
    step(RISE_LAT + 2);
    chk(rst_n === 1'b0, "R8", "rst_n_o while button still held", int'(rst_n), 0);
    mr_n = 1'b1; expect_rise("R8", 1);
    step(RISE_LAT + 5);

    chk(expq.size() == 0, "R2", "expected edges not seen", expq.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R2: watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule